// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch-stage state machine of every hardware thread in a multithreaded core. Every cycle it takes in stall and release pulses from the four stages further down the pipeline, redirect requests from the retire stage and the decode stage, a signal that the reorder buffer is still flushing, events from the instruction-cache interface (request sent, request refused, response returned, retry granted), and fault and quiesce indications. From these it computes the next status of each thread.

It presents the registered status of each thread, a one-cycle pulse whenever any thread changed status, a flag that tells whether the fetch stage has useful work this cycle, the shared "cache interface blocked by a refused request" flag, and two diagnostic pulses: one for a cache response that no thread was waiting for, and one for a release pulse that broke the stall protocol. Redirect addresses and cache hit detection are handled elsewhere.

Every input sampled at a clock edge shows its effect in the status outputs right after that edge. The only exception is `stage_active`, which is decoded directly from the registered status and the `thread_active` input.

Top module: `fetch_thread_status`

## Requirements
- R1: Each thread keeps four sticky stall flags, one per downstream stage (stage 0 decode, 1 rename, 2 execute, 3 commit). The flag for thread t and stage s sits at bit t*4+s of `block_pulse` and `unblock_pulse`. A block pulse sets the flag and an unblock pulse clears it. An unblock on a flag that is already clear, or an unblock in the same cycle as a block on the same bit, raises `proto_err` for one cycle after the edge.
- R2: After reset every thread is in Running, all stall flags are clear, and `cache_blocked`, `resp_dropped`, `proto_err` and `status_changed` are low. The status of thread t is the 3-bit field `status[3*t+2:3*t]`, encoded as: 0 Running, 1 Squashing, 2 Blocked, 3 WaitResponse, 4 WaitRetry, 5 AccessDone, 6 TrapPending, 7 QuiescePending.
- R3: A commit squash, or a reorder-buffer-still-flushing indication, sends the thread to Squashing whatever its state and whatever else arrives in the same cycle. The indication holds the thread there for as long as it stays high.
- R4: A decode squash sends the thread to Squashing. If the thread is already in Squashing, the decode squash has no effect, and the thread is released to Running as though nothing had arrived.
- R5: When no squash is pending, any set stall flag (including one set in the same cycle) or the global `ctx_switch` input sends the thread to Blocked. This does not apply to a thread in WaitResponse, WaitRetry, TrapPending or QuiescePending, which keeps its state. A thread in Blocked or Squashing with no squash and no stall returns to Running.
- R6: A thread in Running that reports a sent request enters WaitResponse and stays there until a response with its index arrives. On that response it moves to Blocked if it is stalled, and to AccessDone otherwise. AccessDone returns to Running in the next cycle.
- R7: A response for a thread that is not in WaitResponse, or for one that is squashed in the same cycle, is discarded and raises `resp_dropped` for one cycle after the edge.
- R8: A refused request from a Running thread moves that thread to WaitRetry and sets `cache_blocked`. When several threads are refused in the same cycle, the lowest index wins. A refusal while `cache_blocked` is set, or from a thread that lost the arbitration, has no effect. `retry_grant` moves the owner to WaitResponse and clears `cache_blocked`.
- R9: A squash (commit, reorder buffer or decode) of the thread that owns the refused request cancels it and clears `cache_blocked`.
- R10: In Running, a fault moves the thread to TrapPending and a quiesce moves it to QuiescePending. Fault wins over quiesce, quiesce over a refusal, and a refusal over a sent request. TrapPending and QuiescePending hold until a squash arrives.
- R11: `stage_active` is high exactly when at least one thread with `thread_active` set is in Running, Squashing or AccessDone.
- R12: `status_changed` is high for the one cycle after an edge at which any thread's status changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_active | input | NUM_THREADS | Threads that count toward stage activity |
| block_pulse | input | 4*NUM_THREADS | Stall set pulses, bit t*4+stage |
| unblock_pulse | input | 4*NUM_THREADS | Stall release pulses, bit t*4+stage |
| ctx_switch | input | 1 | Global stall for a context switch |
| commit_squash | input | NUM_THREADS | Redirect from the retire stage |
| rob_squashing | input | NUM_THREADS | Reorder buffer still flushing |
| decode_squash | input | NUM_THREADS | Redirect from the decode stage |
| req_sent | input | NUM_THREADS | Cache request accepted for the thread |
| req_refused | input | NUM_THREADS | Cache request refused for the thread |
| resp_valid | input | 1 | Cache response present |
| resp_tid | input | TID_W | Thread index of the response |
| retry_grant | input | 1 | Cache can take the refused request again |
| fault | input | NUM_THREADS | Fetch fault for the thread |
| quiesce | input | NUM_THREADS | Quiesce seen for the thread |
| status | output | 3*NUM_THREADS | Per-thread status fields |
| status_changed | output | 1 | Some thread changed status at the last edge |
| stage_active | output | 1 | Fetch stage has useful work |
| cache_blocked | output | 1 | A refused request is pending retry |
| resp_dropped | output | 1 | The last response was discarded |
| proto_err | output | 1 | The last unblock broke the stall protocol |

## Verification
The bench sweeps every thread and every stall source through block, hold and release. It then aims at the orderings where a wrong priority shows up. A commit squash arriving together with a decode squash and a stall must land in Squashing, not Blocked. A repeated decode squash must release the thread rather than hold it. A thread waiting for a response must ignore stalls, and it must land in Blocked on its response when stalled; a design that let it block would lose the miss. Two simultaneous refusals test the lowest-index arbitration, and a squash of the retry owner must free the shared flag; a design that got this wrong would leave the cache blocked forever. Responses that are stale or collide with a squash must be reported as dropped rather than wake the thread.

// File: rtl/fts_pkg.sv
package fts_pkg;

  localparam int STAGES = 4;

  typedef enum logic [2:0] {
    ST_RUN        = 3'd0,
    ST_SQUASH     = 3'd1,
    ST_BLOCKED    = 3'd2,
    ST_WAIT_RESP  = 3'd3,
    ST_WAIT_RETRY = 3'd4,
    ST_ACC_DONE   = 3'd5,
    ST_TRAP       = 3'd6,
    ST_QUIESCE    = 3'd7
  } fstate_t;

  typedef struct packed {
    logic cmt;
    logic rob;
    logic dec;
  } squash_in_t;

  // A squash takes effect unless it is a decode squash on a thread already squashing.
  function automatic logic squash_taken(squash_in_t s, fstate_t cur);
    return s.cmt | s.rob | (s.dec & (cur != ST_SQUASH));
  endfunction

  // States that keep their value when a stall is asserted.
  function automatic logic stall_exempt(fstate_t cur);
    return (cur == ST_WAIT_RESP) || (cur == ST_WAIT_RETRY) ||
           (cur == ST_TRAP) || (cur == ST_QUIESCE);
  endfunction

  // States that give the fetch stage work to do.
  function automatic logic drives_fetch(fstate_t cur);
    return (cur == ST_RUN) || (cur == ST_SQUASH) || (cur == ST_ACC_DONE);
  endfunction

  function automatic logic [STAGES-1:0] next_flags(logic [STAGES-1:0] cur,
                                                   logic [STAGES-1:0] set,
                                                   logic [STAGES-1:0] clr);
    return (cur | set) & ~clr;
  endfunction

endpackage

// File: rtl/fts_stall_flags.sv
module fts_stall_flags
  import fts_pkg::*;
#(
  parameter int NT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NT*STAGES-1:0] set_i,
  input  logic [NT*STAGES-1:0] clr_i,
  output logic [NT*STAGES-1:0] flags_q,
  output logic [NT*STAGES-1:0] flags_d,
  output logic               proto_err_q
);

  logic [NT-1:0] err_t;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    assign flags_d[t*STAGES +: STAGES] =
      next_flags(flags_q[t*STAGES +: STAGES], set_i[t*STAGES +: STAGES],
                 clr_i[t*STAGES +: STAGES]);
    assign err_t[t] = |(clr_i[t*STAGES +: STAGES] &
                        (~flags_q[t*STAGES +: STAGES] | set_i[t*STAGES +: STAGES]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q     <= '0;
      proto_err_q <= 1'b0;
    end else begin
      flags_q     <= flags_d;
      proto_err_q <= |err_t;
    end
  end

endmodule

// File: rtl/fts_thread_fsm.sv
module fts_thread_fsm
  import fts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  squash_in_t sq_i,
  input  logic       stalled_i,
  input  logic       resp_hit_i,
  input  logic       grant_hit_i,
  input  logic       refuse_win_i,
  input  logic       req_sent_i,
  input  logic       fault_i,
  input  logic       quiesce_i,
  input  logic       req_refused_i,
  output fstate_t    state_q,
  output fstate_t    state_d,
  output logic       sq_taken_o,
  output logic       refuse_cand_o,
  output logic       resp_accept_o
);

  logic blocks;
  logic releases;
  logic quiet;

  assign sq_taken_o    = squash_taken(sq_i, state_q);
  assign blocks        = stalled_i && !stall_exempt(state_q);
  assign releases      = (state_q == ST_BLOCKED) || (state_q == ST_SQUASH);
  assign quiet         = !sq_taken_o && !blocks && !releases;
  assign refuse_cand_o = quiet && (state_q == ST_RUN) && !fault_i && !quiesce_i &&
                         req_refused_i;
  assign resp_accept_o = resp_hit_i && quiet && (state_q == ST_WAIT_RESP);

  always_comb begin
    state_d = state_q;
    if (sq_taken_o) begin
      state_d = ST_SQUASH;
    end else if (blocks) begin
      state_d = ST_BLOCKED;
    end else if (releases) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_WAIT_RESP:  if (resp_hit_i) state_d = stalled_i ? ST_BLOCKED : ST_ACC_DONE;
        ST_WAIT_RETRY: if (grant_hit_i) state_d = ST_WAIT_RESP;
        ST_ACC_DONE:   state_d = ST_RUN;
        ST_RUN: begin
          if (fault_i)           state_d = ST_TRAP;
          else if (quiesce_i)    state_d = ST_QUIESCE;
          else if (refuse_win_i) state_d = ST_WAIT_RETRY;
          else if (req_sent_i)   state_d = ST_WAIT_RESP;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/fts_retry_arb.sv
module fts_retry_arb #(
  parameter int NT = 2,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] cand_i,
  input  logic          grant_i,
  input  logic [NT-1:0] sq_taken_i,
  output logic [NT-1:0] win_o,
  output logic [NT-1:0] grant_hit_o,
  output logic          blocked_q
);

  logic [TW-1:0] owner_q;
  logic [TW-1:0] win_idx;
  logic          found;
  logic          owner_squashed;

  always_comb begin
    found   = 1'b0;
    win_o   = '0;
    win_idx = '0;
    for (int i = 0; i < NT; i++) begin
      if (!found && cand_i[i] && !blocked_q) begin
        found    = 1'b1;
        win_o[i] = 1'b1;
        win_idx  = TW'(i);
      end
    end
  end

  always_comb begin
    owner_squashed = 1'b0;
    for (int i = 0; i < NT; i++) begin
      grant_hit_o[i] = grant_i && blocked_q && (owner_q == TW'(i));
      if (owner_q == TW'(i) && sq_taken_i[i]) owner_squashed = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blocked_q <= 1'b0;
      owner_q   <= '0;
    end else if (blocked_q) begin
      if (grant_i || owner_squashed) blocked_q <= 1'b0;
    end else if (found) begin
      blocked_q <= 1'b1;
      owner_q   <= win_idx;
    end
  end

endmodule

// File: rtl/fetch_thread_status.sv
module fetch_thread_status
  import fts_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int FLAG_W = NUM_THREADS * STAGES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_THREADS-1:0]   thread_active,
  input  logic [FLAG_W-1:0]        block_pulse,
  input  logic [FLAG_W-1:0]        unblock_pulse,
  input  logic                     ctx_switch,
  input  logic [NUM_THREADS-1:0]   commit_squash,
  input  logic [NUM_THREADS-1:0]   rob_squashing,
  input  logic [NUM_THREADS-1:0]   decode_squash,
  input  logic [NUM_THREADS-1:0]   req_sent,
  input  logic [NUM_THREADS-1:0]   req_refused,
  input  logic                     resp_valid,
  input  logic [TID_W-1:0]         resp_tid,
  input  logic                     retry_grant,
  input  logic [NUM_THREADS-1:0]   fault,
  input  logic [NUM_THREADS-1:0]   quiesce,
  output logic [3*NUM_THREADS-1:0] status,
  output logic                     status_changed,
  output logic                     stage_active,
  output logic                     cache_blocked,
  output logic                     resp_dropped,
  output logic                     proto_err
);

  logic [FLAG_W-1:0]      stall_q;
  logic [FLAG_W-1:0]      stall_d;
  logic [NUM_THREADS-1:0] sq_taken;
  logic [NUM_THREADS-1:0] refuse_cand;
  logic [NUM_THREADS-1:0] refuse_win;
  logic [NUM_THREADS-1:0] grant_hit;
  logic [NUM_THREADS-1:0] resp_accept;
  logic [NUM_THREADS-1:0] changed;
  logic [NUM_THREADS-1:0] busy;
  logic                   chg_q;
  logic                   drop_q;

  fts_stall_flags #(.NT(NUM_THREADS)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (block_pulse),
    .clr_i      (unblock_pulse),
    .flags_q    (stall_q),
    .flags_d    (stall_d),
    .proto_err_q(proto_err)
  );

  fts_retry_arb #(.NT(NUM_THREADS)) u_retry (
    .clk        (clk),
    .rst_n      (rst_n),
    .cand_i     (refuse_cand),
    .grant_i    (retry_grant),
    .sq_taken_i (sq_taken),
    .win_o      (refuse_win),
    .grant_hit_o(grant_hit),
    .blocked_q  (cache_blocked)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    localparam logic [TID_W-1:0] TID = TID_W'(t);
    fstate_t    cur;
    fstate_t    nxt;
    squash_in_t sq;
    logic       stalled;

    assign sq      = '{cmt: commit_squash[t], rob: rob_squashing[t], dec: decode_squash[t]};
    assign stalled = (|stall_d[t*STAGES +: STAGES]) | ctx_switch;

    fts_thread_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .sq_i         (sq),
      .stalled_i    (stalled),
      .resp_hit_i   (resp_valid && (resp_tid == TID)),
      .grant_hit_i  (grant_hit[t]),
      .refuse_win_i (refuse_win[t]),
      .req_sent_i   (req_sent[t]),
      .fault_i      (fault[t]),
      .quiesce_i    (quiesce[t]),
      .req_refused_i(req_refused[t]),
      .state_q      (cur),
      .state_d      (nxt),
      .sq_taken_o   (sq_taken[t]),
      .refuse_cand_o(refuse_cand[t]),
      .resp_accept_o(resp_accept[t])
    );

    assign status[3*t +: 3] = cur;
    assign changed[t]       = (nxt != cur);
    assign busy[t]          = thread_active[t] && drives_fetch(cur);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      chg_q  <= |changed;
      drop_q <= resp_valid && !(|resp_accept);
    end
  end

  assign status_changed = chg_q;
  assign resp_dropped   = drop_q;
  assign stage_active   = |busy;

endmodule

// File: rtl/fts_checker.sv
module fts_checker
  import fts_pkg::*;
#(
  parameter int NT = 2,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3*NT-1:0]   status,
  input logic [NT-1:0]     commit_squash,
  input logic [NT-1:0]     sq_taken,
  input logic              resp_valid,
  input logic [TW-1:0]     resp_tid,
  input logic              resp_dropped,
  input logic              cache_blocked,
  input logic [NT*STAGES-1:0] unblock_pulse,
  input logic [NT*STAGES-1:0] stall_q,
  input logic              proto_err
);

  fstate_t st [NT];
  int      retry_cnt;
  logic    drop_expect;

  always_comb begin
    retry_cnt   = 0;
    drop_expect = 1'b0;
    for (int i = 0; i < NT; i++) begin
      st[i] = fstate_t'(status[3*i +: 3]);
      if (st[i] == ST_WAIT_RETRY) retry_cnt++;
      if (resp_valid && resp_tid == TW'(i) && st[i] != ST_WAIT_RESP) drop_expect = 1'b1;
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_t
    AST_COMMIT_SQUASH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      commit_squash[t] |=> st[t] == ST_SQUASH); // R3
    AST_MISS_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st[t] == ST_WAIT_RESP && !sq_taken[t] && !(resp_valid && resp_tid == TW'(t)))
      |=> st[t] == ST_WAIT_RESP); // R6
    AST_PARKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ((st[t] == ST_TRAP || st[t] == ST_QUIESCE) && !sq_taken[t])
      |=> st[t] == $past(st[t])); // R10
  end

  AST_RETRY_OWNER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cache_blocked |-> retry_cnt == 1); // R8
  AST_RETRY_OWNER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cache_blocked |-> retry_cnt == 0); // R9
  AST_STALE_RESP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    drop_expect |=> resp_dropped); // R7
  AST_BAD_UNBLOCK_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (|(unblock_pulse & ~stall_q)) |=> proto_err); // R1

endmodule

bind fetch_thread_status fts_checker #(.NT(NUM_THREADS)) u_fts_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .status       (status),
  .commit_squash(commit_squash),
  .sq_taken     (sq_taken),
  .resp_valid   (resp_valid),
  .resp_tid     (resp_tid),
  .resp_dropped (resp_dropped),
  .cache_blocked(cache_blocked),
  .unblock_pulse(unblock_pulse),
  .stall_q      (stall_q),
  .proto_err    (proto_err)
);

// File: tb/fetch_thread_status_tb.sv
`timescale 1ns/1ps
module fetch_thread_status_tb;

  localparam int NT = 2;
  localparam int S_RUN = 0, S_SQ = 1, S_BLK = 2, S_WRESP = 3, S_WRETRY = 4,
                 S_DONE = 5, S_TRAP = 6, S_QUI = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NT-1:0]   thread_active = '1;
  logic [NT*4-1:0] block_pulse = '0, unblock_pulse = '0;
  logic            ctx_switch = 1'b0;
  logic [NT-1:0]   commit_squash = '0, rob_squashing = '0, decode_squash = '0;
  logic [NT-1:0]   req_sent = '0, req_refused = '0, fault = '0, quiesce = '0;
  logic            resp_valid = 1'b0;
  logic [0:0]      resp_tid = '0;
  logic            retry_grant = 1'b0;
  logic [3*NT-1:0] status;
  logic            status_changed, stage_active, cache_blocked, resp_dropped, proto_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fetch_thread_status #(.NUM_THREADS(NT)) u_dut (
    .clk(clk), .rst_n(rst_n), .thread_active(thread_active),
    .block_pulse(block_pulse), .unblock_pulse(unblock_pulse), .ctx_switch(ctx_switch),
    .commit_squash(commit_squash), .rob_squashing(rob_squashing),
    .decode_squash(decode_squash), .req_sent(req_sent), .req_refused(req_refused),
    .resp_valid(resp_valid), .resp_tid(resp_tid), .retry_grant(retry_grant),
    .fault(fault), .quiesce(quiesce), .status(status),
    .status_changed(status_changed), .stage_active(stage_active),
    .cache_blocked(cache_blocked), .resp_dropped(resp_dropped), .proto_err(proto_err)
  );

  function automatic int st(int t);
    return int'(status[3*t +: 3]);
  endfunction

  function automatic int bitpos(int t, int s);
    return t*4 + s;
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_inputs();
    block_pulse = '0; unblock_pulse = '0; ctx_switch = 1'b0;
    commit_squash = '0; rob_squashing = '0; decode_squash = '0;
    req_sent = '0; req_refused = '0; fault = '0; quiesce = '0;
    resp_valid = 1'b0; resp_tid = '0; retry_grant = 1'b0;
  endtask

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R2 reset state
    chk("R2", "t0 status", st(0), S_RUN);
    chk("R2", "t1 status", st(1), S_RUN);
    chk("R2", "cache_blocked", cache_blocked, 0);
    chk("R2", "resp_dropped", resp_dropped, 0);
    chk("R2", "proto_err", proto_err, 0);
    chk("R12", "no change after reset", status_changed, 0);
    chk("R11", "active after reset", stage_active, 1);

    // R1/R5 sweep of every thread and stall source
    for (int t = 0; t < NT; t++) begin
      for (int s = 0; s < 4; s++) begin
        block_pulse[bitpos(t, s)] = 1'b1; step(); idle_inputs();
        chk("R5", $sformatf("t%0d stage%0d blocks", t, s), st(t), S_BLK);
        chk("R5", "other thread runs", st(1-t), S_RUN);
        chk("R12", "change pulse", status_changed, 1);
        step();
        chk("R1", $sformatf("t%0d stage%0d flag sticky", t, s), st(t), S_BLK);
        chk("R12", "no change pulse", status_changed, 0);
        unblock_pulse[bitpos(t, s)] = 1'b1; step(); idle_inputs();
        chk("R5", $sformatf("t%0d stage%0d released", t, s), st(t), S_RUN);
        chk("R1", "legal unblock no error", proto_err, 0);
      end
    end

    // R5 context switch
    ctx_switch = 1'b1; step(); idle_inputs();
    chk("R5", "ctx t0", st(0), S_BLK);
    chk("R5", "ctx t1", st(1), S_BLK);
    chk("R11", "all blocked inactive", stage_active, 0);
    step();
    chk("R5", "ctx release t0", st(0), S_RUN);

    // R3 commit squash beats decode squash and stall
    block_pulse[bitpos(0, 0)] = 1'b1; commit_squash[0] = 1'b1; decode_squash[0] = 1'b1;
    step(); idle_inputs();
    chk("R3", "commit squash wins", st(0), S_SQ);
    step();
    chk("R5", "stall after squash", st(0), S_BLK);
    unblock_pulse[bitpos(0, 0)] = 1'b1; step(); idle_inputs();
    chk("R5", "release after squash", st(0), S_RUN);
    rob_squashing[1] = 1'b1; step();
    chk("R3", "rob flush squashes", st(1), S_SQ);
    step(); idle_inputs();
    chk("R3", "rob flush holds", st(1), S_SQ);
    step();
    chk("R5", "rob flush released", st(1), S_RUN);

    // R4 decode squash ignored when already squashing
    decode_squash[0] = 1'b1; step();
    chk("R4", "decode squash", st(0), S_SQ);
    step(); idle_inputs();
    chk("R4", "repeat decode squash ignored", st(0), S_RUN);

    // R6 miss path with stall
    req_sent[0] = 1'b1; step(); idle_inputs();
    chk("R6", "req sent", st(0), S_WRESP);
    block_pulse[bitpos(0, 1)] = 1'b1; step(); idle_inputs();
    chk("R6", "wait ignores stall", st(0), S_WRESP);
    resp_valid = 1'b1; resp_tid = 1'b0; step(); idle_inputs();
    chk("R6", "resp while stalled", st(0), S_BLK);
    chk("R7", "accepted resp not dropped", resp_dropped, 0);
    unblock_pulse[bitpos(0, 1)] = 1'b1; step(); idle_inputs();
    chk("R6", "released", st(0), S_RUN);
    req_sent[1] = 1'b1; step(); idle_inputs();
    resp_valid = 1'b1; resp_tid = 1'b1; step(); idle_inputs();
    chk("R6", "resp unstalled", st(1), S_DONE);
    step();
    chk("R6", "access done returns", st(1), S_RUN);

    // R7 dropped responses
    resp_valid = 1'b1; resp_tid = 1'b0; step(); idle_inputs();
    chk("R7", "stale resp dropped", resp_dropped, 1);
    chk("R7", "stale resp no effect", st(0), S_RUN);
    step();
    chk("R7", "drop pulse one cycle", resp_dropped, 0);
    req_sent[0] = 1'b1; step(); idle_inputs();
    resp_valid = 1'b1; resp_tid = 1'b0; commit_squash[0] = 1'b1; step(); idle_inputs();
    chk("R7", "resp with squash dropped", resp_dropped, 1);
    chk("R3", "squash over resp", st(0), S_SQ);
    step();

    // R8 retry arbitration
    req_refused = 2'b11; step(); idle_inputs();
    chk("R8", "t0 wins retry", st(0), S_WRETRY);
    chk("R8", "t1 loses", st(1), S_RUN);
    chk("R8", "cache blocked", cache_blocked, 1);
    req_refused[1] = 1'b1; step(); idle_inputs();
    chk("R8", "refuse while blocked ignored", st(1), S_RUN);
    retry_grant = 1'b1; step(); idle_inputs();
    chk("R8", "grant to wait", st(0), S_WRESP);
    chk("R8", "grant clears", cache_blocked, 0);
    resp_valid = 1'b1; resp_tid = 1'b0; step(); idle_inputs();
    step();

    // R9 squash cancels retry
    req_refused[1] = 1'b1; step(); idle_inputs();
    chk("R9", "t1 owns retry", st(1), S_WRETRY);
    commit_squash[1] = 1'b1; step(); idle_inputs();
    chk("R9", "squash cancels", cache_blocked, 0);
    chk("R9", "owner squashed", st(1), S_SQ);
    step();

    // R10 trap and quiesce
    fault[0] = 1'b1; quiesce[0] = 1'b1; step(); idle_inputs();
    chk("R10", "fault over quiesce", st(0), S_TRAP);
    block_pulse[bitpos(0, 2)] = 1'b1; step(); idle_inputs();
    chk("R10", "trap ignores stall", st(0), S_TRAP);
    unblock_pulse[bitpos(0, 2)] = 1'b1; step(); idle_inputs();
    quiesce[1] = 1'b1; req_sent[1] = 1'b1; step(); idle_inputs();
    chk("R10", "quiesce over req", st(1), S_QUI);
    chk("R10", "trap holds", st(0), S_TRAP);
    chk("R11", "parked threads inactive", stage_active, 0);
    decode_squash[0] = 1'b1; step(); idle_inputs();
    chk("R10", "squash frees trap", st(0), S_SQ);
    chk("R11", "squashing is active", stage_active, 1);
    thread_active = 2'b10; #1;
    chk("R11", "inactive thread masked", stage_active, 0);
    thread_active = 2'b11; #1;
    commit_squash[1] = 1'b1; step(); idle_inputs();
    step();
    chk("R10", "quiesce freed", st(1), S_RUN);

    // R1 protocol errors
    unblock_pulse[bitpos(1, 1)] = 1'b1; step(); idle_inputs();
    chk("R1", "unblock on clear flag", proto_err, 1);
    step();
    chk("R1", "error pulse ends", proto_err, 0);
    block_pulse[bitpos(0, 3)] = 1'b1; unblock_pulse[bitpos(0, 3)] = 1'b1; step(); idle_inputs();
    chk("R1", "block with unblock", proto_err, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule